// File: doc/BRIEF.md
# Seeded Additive Bit Scrambler

This block whitens a serial bit stream so that long runs of ones or zeros are broken up before transmission. Every bit marked valid is combined by exclusive-OR with one bit of a pseudo-random keystream. The keystream comes from a 15-bit linear-feedback shift register. Because the keystream does not depend on the data, running the scrambled stream through a second copy of the same block gives back the original stream. The second copy needs the same seed and must restart at the same data position.

A start pulse marks where a frame of data begins and reloads the agreed seed. The transmitter and receiver therefore agree on only two things: the seed value, and the bit at which the data starts. The register steps only on valid cycles, so idle gaps in the stream do not shift the keystream. An all-zero seed would lock the register, so the block replaces it with the value 1.

Top module: `bit_whitener`

## Requirements
- R1: The register is 15 bits wide, numbered 14 down to 0. The key bit for a cycle is bit 14 XOR bit 13 of the state in use. One step shifts that state left by one place and puts the key bit into bit 0, which gives the polynomial x^15 + x^14 + 1.
- R2: A valid input bit appears on the output one clock later, XORed with the key bit. The output valid flag is the input valid flag delayed by exactly one clock.
- R3: The register steps only in cycles where the input valid flag is high. In all other cycles it keeps its value.
- R4: A start pulse loads the seed in that same cycle. A valid bit that arrives together with the start pulse is scrambled with the key from the seed. A start pulse without valid leaves the register holding the seed.
- R5: After reset, both outputs are 0 and the register holds the seed. The first valid bit after reset therefore uses the seeded state.
- R6: A seed parameter of 0 is replaced by 1, and the register state is never all zeros.
- R7: The output bit is 0 in every cycle where the output valid flag is 0.
- R8: A second instance with the same seed restores the original stream. It takes the first instance's outputs as input and receives the start pulse one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | Start-of-data pulse; reloads the seed |
| bitValid | input | 1 | Qualifies bitIn |
| bitIn | input | 1 | Serial data bit |
| bitOut | output | 1 | Scrambled bit, registered |
| bitOutValid | output | 1 | Qualifier for bitOut |

## Verification
A seed reload and a keystream step can happen in the same cycle when the start pulse and the valid flag are both high. In that case the bit must be scrambled with the key from the seed, and the register must then hold one step past the seed. The bench forces this case in a directed test and also produces it often in random traffic, where start and valid are drawn independently. Each output is compared with a bench model built only from R1 to R4. A receiving instance, with its start pulse delayed by one clock, must return the original bits two clocks after they were applied.

// File: rtl/whitener_pkg.sv
package whitener_pkg;
  typedef struct packed {
    logic loadSeed;
    logic advance;
  } whStrobe_t;
endpackage

// File: rtl/whitener_ctrl.sv
module whitener_ctrl
  import whitener_pkg::*;
(
  input  logic      startIn,
  input  logic      validIn,
  output whStrobe_t strobes
);
  always_comb begin
    strobes.loadSeed = startIn;
    strobes.advance  = validIn;
  end
endmodule

// File: rtl/whitener_dp.sv
module whitener_dp
  import whitener_pkg::*;
#(
  parameter int STATE_W = 15,
  parameter int TAP_A   = 14,
  parameter int TAP_B   = 13,
  parameter int SEED    = 15'h7FFF
) (
  input  logic      clk,
  input  logic      rstN,
  input  whStrobe_t strobes,
  input  logic      dataIn,
  output logic      dataOut,
  output logic      validOut
);
  localparam logic [STATE_W-1:0] SEED_RAW = STATE_W'(SEED);
  localparam logic [STATE_W-1:0] SEED_EFF =
    (SEED_RAW == '0) ? STATE_W'(1) : SEED_RAW;

  logic [STATE_W-1:0] lfsrState;
  logic [STATE_W-1:0] curState;
  logic [STATE_W-1:0] nextState;
  logic               keyBit;

  always_comb begin
    curState  = strobes.loadSeed ? SEED_EFF : lfsrState;
    keyBit    = curState[TAP_A] ^ curState[TAP_B];
    nextState = {curState[STATE_W-2:0], keyBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrState <= SEED_EFF;
      dataOut   <= 1'b0;
      validOut  <= 1'b0;
    end else begin
      lfsrState <= strobes.advance ? nextState : curState;
      validOut  <= strobes.advance;
      dataOut   <= strobes.advance ? (dataIn ^ keyBit) : 1'b0;
    end
  end

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.loadSeed) |=> $stable(lfsrState));

  assert_seed_loaded_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadSeed && !strobes.advance) |=> (lfsrState == SEED_EFF));

  assert_never_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0);

  assert_quiet_output_R7: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> !dataOut);
endmodule

// File: rtl/bit_whitener.sv
module bit_whitener
  import whitener_pkg::*;
#(
  parameter int SEED = 15'h7FFF
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameStart,
  input  logic bitValid,
  input  logic bitIn,
  output logic bitOut,
  output logic bitOutValid
);
  localparam int STATE_W = 15;
  localparam int TAP_A   = STATE_W - 1;
  localparam int TAP_B   = STATE_W - 2;

  whStrobe_t strobes;

  whitener_ctrl u_ctrl (
    .startIn (frameStart),
    .validIn (bitValid),
    .strobes (strobes)
  );

  whitener_dp #(
    .STATE_W (STATE_W),
    .TAP_A   (TAP_A),
    .TAP_B   (TAP_B),
    .SEED    (SEED)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dataIn   (bitIn),
    .dataOut  (bitOut),
    .validOut (bitOutValid)
  );

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (bitOutValid == $past(bitValid)));
endmodule

// File: tb/bit_whitener_test.sv
module bit_whitener_test;
  localparam int SEED_A = 15'h2B6D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic bitOut, bitOutValid;
  logic zOut, zOutValid;
  logic rxOut, rxOutValid;
  logic startDly;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bit_whitener #(.SEED(SEED_A)) uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitValid(bitValid),
    .bitIn(bitIn), .bitOut(bitOut), .bitOutValid(bitOutValid));

  bit_whitener #(.SEED(0)) uzero (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitValid(bitValid),
    .bitIn(bitIn), .bitOut(zOut), .bitOutValid(zOutValid));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) startDly <= 1'b0;
    else startDly <= frameStart;

  bit_whitener #(.SEED(SEED_A)) urx (
    .clk(clk), .rstN(rstN), .frameStart(startDly), .bitValid(bitOutValid),
    .bitIn(bitOut), .bitOut(rxOut), .bitOutValid(rxOutValid));

  logic [14:0] mdlA, mdlZ;
  logic expA, expZ, expV;
  logic hist1V, hist1B, hist2V, hist2B;

  function automatic logic keyOf(input logic [14:0] s);
    return s[14] ^ s[13];
  endfunction

  function automatic logic [14:0] stepOf(input logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, then check at the next falling edge.
  task automatic cycle(input logic st, input logic v, input logic b);
    logic [14:0] curA, curZ;
    frameStart = st; bitValid = v; bitIn = b;
    curA = st ? 15'(SEED_A) : mdlA;
    curZ = st ? 15'd1 : mdlZ;
    expV = v;
    expA = v ? (b ^ keyOf(curA)) : 1'b0;
    expZ = v ? (b ^ keyOf(curZ)) : 1'b0;
    mdlA = v ? stepOf(curA) : curA;
    mdlZ = v ? stepOf(curZ) : curZ;
    @(negedge clk);
    check("R2 valid", bitOutValid, expV);
    if (expV) check("R1 R2 R4 data", bitOut, expA);
    else check("R7 idle data", bitOut, 1'b0);
    check("R6 zero-seed data", zOut, expZ);
    check("R8 rx valid", rxOutValid, hist1V);
    if (hist1V) check("R8 restore", rxOut, hist1B);
    hist2V = hist1V; hist2B = hist1B;
    hist1V = v; hist1B = b;
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    mdlA = 15'(SEED_A); mdlZ = 15'd1;
    hist1V = 0; hist1B = 0; hist2V = 0; hist2B = 0;
    repeat (3) @(negedge clk);
    check("R5 reset valid", bitOutValid, 1'b0);
    check("R5 reset data", bitOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R5: first valid bits after reset use the seed with no start pulse
    cycle(0, 1, 1); cycle(0, 1, 0); cycle(0, 1, 1);
    // R3: idle gap keeps keystream position
    cycle(0, 0, 1); cycle(0, 0, 0); cycle(0, 1, 1);
    // R4: start together with valid
    cycle(1, 1, 0); cycle(0, 1, 0); cycle(0, 1, 0);
    // R4: start alone, then data
    cycle(1, 0, 1); cycle(0, 1, 1); cycle(0, 1, 1);
    // R1: long zero run exposes raw keystream
    for (int i = 0; i < 40; i++) cycle(0, 1, 0);
    // Random traffic, start and valid independently drawn
    for (int i = 0; i < 4000; i++)
      cycle(($urandom % 23) == 0, ($urandom % 4) != 0, 1'($urandom));
    cycle(0, 0, 0); cycle(0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule